// File: doc/BRIEF.md
# Serial Receiver with Two-Entry Character Queue

This block is the receive half of an asynchronous serial port. The line input passes through a synchronizer and then into an oversampling shift engine. One enable strobe per sample period paces that engine, and the strobe comes from a baud divider outside the block. Each completed character goes into a two-entry queue. Every entry carries the character, its ninth bit, and its own framing and parity error flags. The status outputs always describe the oldest unread entry. A one-cycle read strobe removes that entry.

If a third character completes while the queue is full, it is held in the receive engine. An overrun is marked only when yet another start bit is confirmed while that character is still held. The held character then carries the overrun mark into the queue, and the newly arriving character is lost. An optional address-filter mode keeps only frames whose last data bit is one. A receive interrupt is raised while unread data exists and the interrupt enable is set.

Top module: `uart_rx_fifo`

## Requirements
- R1: The queue holds up to two characters in arrival order. A `rd_en` pulse while `ready` is high removes the head entry. A `rd_en` pulse while the queue is empty changes nothing.
- R2: `ready` is 1 exactly when at least one unread character is queued. `irq` equals `irq_en AND ready`.
- R3: A frame ends at the first stop bit. `frame_err` of the entry is 1 when that bit is sampled as 0. Later stop bits are never examined.
- R4: `par_mode` encoding: 00 = no parity, 01 = no parity, 10 = even parity, 11 = odd parity. The mode is captured when the start bit is detected. With parity on, one parity bit follows the data. `par_err` is set only if parity was on at capture and the received bit does not match.
- R5: A character that completes while the queue is full is held. If a new start bit is confirmed while a character is held and the queue is still full, the held character is marked with `overrun`, and the frame behind that start bit is discarded.
- R6: `rd_data`, `rd_bit9`, `frame_err`, `par_err` and `overrun` describe the head entry and stay stable until it is read. All of them are 0 while the queue is empty.
- R7: While `rx_en` is 0, the queue and any held character are flushed, a frame in progress is abandoned, and all status outputs read 0.
- R8: With `addr_filt` at 1, a frame whose last data bit is 0 is dropped and never enters the queue. The last data bit is bit 8 in 9-bit mode and otherwise the top data bit.
- R9: `char_size` encoding: 0..3 select 5..8 data bits, 7 selects 9 bits, and 4..6 act as 8 bits. Data bits that are not received read as 0. `rd_bit9` is the ninth bit in 9-bit mode and 0 otherwise.
- R10: A low level on the idle line starts a frame. The start is confirmed by a majority vote of samples OSR/2-1, OSR/2 and OSR/2+1. A start that votes high returns the receiver to idle and stores nothing.
- R11: Frame layout is a low start bit, then data least significant bit first, then the optional parity bit, then the stop bit. Every bit is taken as the majority of its three middle samples, one bit per OSR strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes |
| addr_filt | input | 1 | Address-filter mode |
| par_mode | input | 2 | Parity mode (see R4) |
| char_size | input | 3 | Character size code (see R9) |
| samp_tick | input | 1 | Sample strobe, OSR per bit |
| rxd | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Read strobe, pops the head |
| irq_en | input | 1 | Receive interrupt enable |
| rd_data | output | 8 | Head character, low byte |
| rd_bit9 | output | 1 | Head ninth bit |
| ready | output | 1 | Unread data present |
| frame_err | output | 1 | Head framing error |
| par_err | output | 1 | Head parity error |
| overrun | output | 1 | Head overrun mark |
| irq | output | 1 | Receive interrupt |

## Verification
The bench fills the queue and the held slot, then confirms one more start bit. A design that counted overrun at the held character instead of at the next start bit would flag the wrong entry. A design that kept the frame behind the overrun would deliver a character that should be lost. Several cases check timing of capture and checking. The parity mode is changed in the middle of a frame, which catches a design that samples it late. A stop bit held low catches a design that fails to reject the false start left at the end of that frame. Short and 9-bit characters show whether upper bits leak, and address-filtered frames show whether dropped frames still take up a queue slot.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int MAXB = 9;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
   } rx_state_e;

   typedef struct packed {
      logic [MAXB-1:0] word;
      logic            fe;
      logic            pe;
      logic            ovr;
   } rx_entry_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_ff
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '1;
            end else begin
               r[0] <= din;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign dout = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
   import uart_rx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic            rxd,
   input  logic [3:0]      nbits,
   input  logic            par_en,
   input  logic            par_odd,
   output logic            start_det,
   output logic            done,
   output logic [MAXB-1:0] word,
   output logic            last_bit,
   output logic            frame_err,
   output logic            par_err
);
   localparam int CW  = $clog2(OSR);
   localparam int MID = OSR / 2;

   generate
      if (OSR < 8) begin : g_bad_osr
         $error("uart_rx_shift: OSR must be at least 8");
      end
   endgenerate

   rx_state_e       st;
   logic [CW-1:0]   cnt;
   logic [1:0]      v;
   logic [MAXB-1:0] sr;
   logic [3:0]      nb_l, bitn;
   logic            pe_l, po_l, pbit;
   logic            vote;

   assign vote = (v[0] & v[1]) | (v[0] & rxd) | (v[1] & rxd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE;  cnt <= '0;  v <= '0;  sr <= '0;
         nb_l <= 4'd8;   bitn <= '0; pe_l <= 1'b0; po_l <= 1'b0;
         pbit <= 1'b0;   start_det <= 1'b0; done <= 1'b0; frame_err <= 1'b0;
      end else begin
         start_det <= 1'b0;
         done      <= 1'b0;
         if (!en) begin
            st <= RX_IDLE;
         end else if (tick) begin
            if (st == RX_IDLE) begin
               if (!rxd) begin
                  st   <= RX_START;
                  cnt  <= CW'(1);
                  nb_l <= nbits;
                  pe_l <= par_en;
                  po_l <= par_odd;
                  bitn <= '0;
                  sr   <= '0;
               end
            end else begin
               cnt <= (cnt == CW'(OSR-1)) ? '0 : cnt + 1'b1;
               if (cnt == CW'(MID-1)) v[0] <= rxd;
               if (cnt == CW'(MID))   v[1] <= rxd;
               if (cnt == CW'(MID+1)) begin
                  case (st)
                     RX_START: begin
                        if (vote) st <= RX_IDLE;
                        else begin
                           st        <= RX_DATA;
                           start_det <= 1'b1;
                        end
                     end
                     RX_DATA: begin
                        sr   <= {vote, sr[MAXB-1:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == nb_l - 4'd1) st <= pe_l ? RX_PAR : RX_STOP;
                     end
                     RX_PAR: begin
                        pbit <= vote;
                        st   <= RX_STOP;
                     end
                     RX_STOP: begin
                        frame_err <= ~vote;
                        done      <= 1'b1;
                        st        <= RX_IDLE;
                     end
                     default: st <= RX_IDLE;
                  endcase
               end
            end
         end
      end
   end

   assign word     = sr >> (4'd9 - nb_l);
   assign last_bit = sr[MAXB-1];
   assign par_err  = pe_l & (pbit ^ (^word) ^ po_l);

   a_r11_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, done}));
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> st == RX_IDLE);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      flush,
   input  logic      push,
   input  logic      keep,
   input  logic      start_det,
   input  logic      pop,
   input  rx_entry_t din,
   output rx_entry_t head,
   output logic      nonempty
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("uart_rx_queue: DEPTH must be at least 1");
      end
   endgenerate

   rx_entry_t     q   [DEPTH];
   rx_entry_t     q_n [DEPTH];
   rx_entry_t     hold, hold_n;
   logic [CW-1:0] cnt, cnt_n;
   logic          hv, hv_n, doom, doom_n;

   always_comb begin
      q_n = q;  cnt_n = cnt;  hold_n = hold;  hv_n = hv;  doom_n = doom;
      if (pop && cnt != '0) begin
         for (int i = 0; i < DEPTH-1; i++) q_n[i] = q[i+1];
         cnt_n = cnt - 1'b1;
      end
      if (hv && cnt_n < CW'(DEPTH)) begin
         for (int i = 0; i < DEPTH; i++) if (cnt_n == CW'(i)) q_n[i] = hold;
         cnt_n = cnt_n + 1'b1;
         hv_n  = 1'b0;
      end
      if (start_det && hv_n && cnt_n == CW'(DEPTH)) begin
         hold_n.ovr = 1'b1;
         doom_n     = 1'b1;
      end
      if (push) begin
         if (doom) begin
            doom_n = 1'b0;
         end else if (keep) begin
            if (cnt_n < CW'(DEPTH)) begin
               for (int i = 0; i < DEPTH; i++) if (cnt_n == CW'(i)) q_n[i] = din;
               cnt_n = cnt_n + 1'b1;
            end else begin
               hold_n = din;
               hv_n   = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) q[i] <= '0;
         hold <= '0;  cnt <= '0;  hv <= 1'b0;  doom <= 1'b0;
      end else if (flush) begin
         cnt <= '0;  hv <= 1'b0;  doom <= 1'b0;
      end else begin
         q <= q_n;  hold <= hold_n;  cnt <= cnt_n;  hv <= hv_n;  doom <= doom_n;
      end
   end

   assign head     = q[0];
   assign nonempty = (cnt != '0);

   a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r1_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      pop && cnt != '0 && !hv && !push && !flush |=> cnt == $past(cnt) - 1'b1);
   a_r5_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      hv |-> cnt == CW'(DEPTH));
   a_r5_overrun_mark: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && start_det && hv && cnt == CW'(DEPTH) && !pop |=> hv && hold.ovr);
   a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt == '0 && !hv);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DEPTH       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en,
   input  logic       addr_filt,
   input  logic [1:0] par_mode,
   input  logic [2:0] char_size,
   input  logic       samp_tick,
   input  logic       rxd,
   input  logic       rd_en,
   input  logic       irq_en,
   output logic [7:0] rd_data,
   output logic       rd_bit9,
   output logic       ready,
   output logic       frame_err,
   output logic       par_err,
   output logic       overrun,
   output logic       irq
);
   logic            rxd_s, start_det, done, last_bit, fe, pe, keep, nonempty;
   logic [3:0]      nbits;
   logic [MAXB-1:0] word;
   rx_entry_t       din, head;

   always_comb begin
      case (char_size)
         3'd0:    nbits = 4'd5;
         3'd1:    nbits = 4'd6;
         3'd2:    nbits = 4'd7;
         3'd7:    nbits = 4'd9;
         default: nbits = 4'd8;
      endcase
   end

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s));

   uart_rx_shift #(.OSR(OSR)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(samp_tick), .rxd(rxd_s),
      .nbits(nbits), .par_en(par_mode[1]), .par_odd(par_mode[0]),
      .start_det(start_det), .done(done), .word(word), .last_bit(last_bit),
      .frame_err(fe), .par_err(pe));

   assign keep = ~addr_filt | last_bit;
   assign din  = '{word: word, fe: fe, pe: pe, ovr: 1'b0};

   uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .flush(~rx_en), .push(done), .keep(keep),
      .start_det(start_det), .pop(rd_en), .din(din), .head(head),
      .nonempty(nonempty));

   assign ready     = nonempty;
   assign rd_data   = nonempty ? head.word[7:0] : 8'h00;
   assign rd_bit9   = nonempty & head.word[8];
   assign frame_err = nonempty & head.fe;
   assign par_err   = nonempty & head.pe;
   assign overrun   = nonempty & head.ovr;
   assign irq       = irq_en & nonempty;

   a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !ready);
endmodule

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
   localparam int OSR = 16;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       rx_en = 1'b0, addr_filt = 1'b0, samp_tick = 1'b1, rxd = 1'b1;
   logic       rd_en = 1'b0, irq_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic [2:0] char_size = 3'd3;
   logic [7:0] rd_data;
   logic       rd_bit9, ready, frame_err, par_err, overrun, irq;

   int  total = 0, bad = 0;
   bit  cmp_on = 1'b0, ended = 1'b0;

   typedef struct { logic [7:0] d; logic b9, fe, pe, ovr; } ent_t;
   ent_t mq[$];
   ent_t mhold;
   bit   mhv = 1'b0, mdoom = 1'b0;

   always #2.5 clk = ~clk;

   uart_rx_fifo #(.OSR(OSR)) uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .addr_filt(addr_filt),
      .par_mode(par_mode), .char_size(char_size), .samp_tick(samp_tick),
      .rxd(rxd), .rd_en(rd_en), .irq_en(irq_en), .rd_data(rd_data),
      .rd_bit9(rd_bit9), .ready(ready), .frame_err(frame_err),
      .par_err(par_err), .overrun(overrun), .irq(irq));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmp_all(string tag);
      ent_t h;
      bit   ne;
      ne = (mq.size() != 0);
      h  = ne ? mq[0] : '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0};
      chk({tag, " R2 ready"}, ready, ne);
      chk({tag, " R2 irq"}, irq, irq_en & ne);
      chk({tag, " R6 data"}, rd_data, h.d);
      chk({tag, " R9 bit9"}, rd_bit9, h.b9);
      chk({tag, " R3 fe"}, frame_err, h.fe);
      chk({tag, " R4 pe"}, par_err, h.pe);
      chk({tag, " R5 ovr"}, overrun, h.ovr);
   endtask

   // per-clock comparison against the model while the line is quiet
   always @(negedge clk) if (cmp_on && rst_n && !ended) cmp_all("R6 clk");

   function automatic logic [2:0] size_code(int nb);
      case (nb)
         5: return 3'd0; 6: return 3'd1; 7: return 3'd2; 9: return 3'd7;
         default: return 3'd3;
      endcase
   endfunction

   task automatic bit_out(logic b);
      rxd = b;
      repeat (OSR) @(negedge clk);
   endtask

   task automatic send_frame(int nb, logic [8:0] d, bit flip_par, bit stop_ok,
                             bit mid_switch);
      logic [8:0] dm;
      logic [1:0] pm;
      ent_t       e;
      bit         keep;
      cmp_on    = 1'b0;
      char_size = size_code(nb);
      pm        = par_mode;
      dm        = (nb == 9) ? d : (d & 9'((1 << nb) - 1));
      if (mq.size() == 2 && mhv) begin
         mhold.ovr = 1'b1;
         mdoom     = 1'b1;
      end
      bit_out(1'b0);
      for (int i = 0; i < nb; i++) begin
         bit_out(dm[i]);
         if (mid_switch && i == 1) par_mode = 2'b00;
      end
      if (pm[1]) bit_out((^dm) ^ pm[0] ^ flip_par);
      bit_out(stop_ok);
      bit_out(1'b1);
      e.d   = dm[7:0];
      e.b9  = (nb == 9) & dm[8];
      e.fe  = ~stop_ok;
      e.pe  = pm[1] & flip_par;
      e.ovr = 1'b0;
      keep  = !addr_filt || dm[nb-1];
      if (mdoom) mdoom = 1'b0;
      else if (keep) begin
         if (mq.size() < 2) mq.push_back(e);
         else begin
            mhold = e;
            mhv   = 1'b1;
         end
      end
      cmp_on = 1'b1;
   endtask

   task automatic do_read();
      cmp_on = 1'b0;
      rd_en  = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (mq.size() != 0) void'(mq.pop_front());
      if (mhv && mq.size() < 2) begin
         mq.push_back(mhold);
         mhv = 1'b0;
      end
      cmp_on = 1'b1;
   endtask

   task automatic drain();
      while (mq.size() != 0) do_read();
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_all("reset");
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      // R1: read on empty queue does nothing
      do_read();
      cmp_all("R1 empty read");

      // R11: basic 8-bit frames, LSB first
      send_frame(8, 9'h0A5, 0, 1, 0);
      cmp_all("R11 A5");
      irq_en = 1'b1;
      @(negedge clk);
      chk("R2 irq on", irq, 1'b1);
      do_read();
      chk("R2 irq off after read", irq, 1'b0);

      // R1: ordering of two entries
      send_frame(8, 9'h03C, 0, 1, 0);
      send_frame(8, 9'h081, 0, 1, 0);
      chk("R1 head first", rd_data, 8'h3C);
      do_read();
      chk("R1 head second", rd_data, 8'h81);
      do_read();
      chk("R1 empty after two", ready, 1'b0);

      // R9: character sizes
      send_frame(5, 9'h1F5, 0, 1, 0);
      chk("R9 5-bit upper zero", rd_data, 8'h15);
      do_read();
      send_frame(6, 9'h0EA, 0, 1, 0);
      chk("R9 6-bit", rd_data, 8'h2A);
      do_read();
      send_frame(7, 9'h0D5, 0, 1, 0);
      chk("R9 7-bit", rd_data, 8'h55);
      do_read();
      send_frame(9, 9'h1A5, 0, 1, 0);
      chk("R9 ninth bit set", rd_bit9, 1'b1);
      do_read();
      send_frame(9, 9'h05A, 0, 1, 0);
      chk("R9 ninth bit clear", rd_bit9, 1'b0);
      do_read();

      // R4: parity modes
      par_mode = 2'b10;
      send_frame(8, 9'h037, 0, 1, 0);
      chk("R4 even ok", par_err, 1'b0);
      do_read();
      send_frame(8, 9'h037, 1, 1, 0);
      chk("R4 even bad", par_err, 1'b1);
      do_read();
      par_mode = 2'b11;
      send_frame(7, 9'h012, 1, 1, 0);
      chk("R4 odd bad", par_err, 1'b1);
      do_read();
      send_frame(7, 9'h012, 0, 1, 0);
      chk("R4 odd ok", par_err, 1'b0);
      do_read();
      par_mode = 2'b01;
      send_frame(8, 9'h0C3, 0, 1, 0);
      chk("R4 mode 01 no parity", par_err, 1'b0);
      do_read();
      par_mode = 2'b10;
      send_frame(8, 9'h066, 1, 1, 1);
      chk("R4 captured at start", par_err, 1'b1);
      do_read();
      par_mode = 2'b00;

      // R3: stop bit low, trailing low is a false start
      send_frame(8, 9'h0F0, 0, 0, 0);
      chk("R3 frame error", frame_err, 1'b1);
      repeat (40) @(negedge clk);
      do_read();
      chk("R3 no extra entry", ready, 1'b0);

      // R10: short glitch on the line
      cmp_on = 1'b0;
      rxd = 1'b0;
      repeat (5) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * OSR) @(negedge clk);
      cmp_on = 1'b1;
      chk("R10 glitch ignored", ready, 1'b0);
      send_frame(8, 9'h042, 0, 1, 0);
      chk("R10 next frame ok", rd_data, 8'h42);
      do_read();

      // R5: held third character, no overrun
      send_frame(8, 9'h011, 0, 1, 0);
      send_frame(8, 9'h022, 0, 1, 0);
      send_frame(8, 9'h033, 0, 1, 0);
      do_read();
      do_read();
      chk("R5 held delivered", rd_data, 8'h33);
      chk("R5 held no ovr", overrun, 1'b0);
      do_read();

      // R5: overrun when a fourth start arrives
      send_frame(8, 9'h0A1, 0, 1, 0);
      send_frame(8, 9'h0A2, 0, 1, 0);
      send_frame(8, 9'h0A3, 0, 1, 0);
      send_frame(8, 9'h0A4, 0, 1, 0);
      chk("R5 head unmarked", overrun, 1'b0);
      do_read();
      do_read();
      chk("R5 held char", rd_data, 8'hA3);
      chk("R5 overrun mark", overrun, 1'b1);
      do_read();
      chk("R5 lost frame absent", ready, 1'b0);

      // R7: flush on disable
      send_frame(8, 9'h077, 0, 0, 0);
      repeat (40) @(negedge clk);
      send_frame(8, 9'h078, 0, 1, 0);
      cmp_on = 1'b0;
      rx_en = 1'b0;
      repeat (3) @(negedge clk);
      mq.delete();
      mhv = 1'b0;
      mdoom = 1'b0;
      chk("R7 ready cleared", ready, 1'b0);
      chk("R7 fe cleared", frame_err, 1'b0);
      rx_en = 1'b1;
      repeat (2) @(negedge clk);
      cmp_on = 1'b1;
      send_frame(8, 9'h079, 0, 1, 0);
      chk("R7 after enable", rd_data, 8'h79);
      do_read();

      // R8: address filtering
      addr_filt = 1'b1;
      send_frame(9, 9'h0AA, 0, 1, 0);
      chk("R8 data frame dropped", ready, 1'b0);
      send_frame(9, 9'h1AB, 0, 1, 0);
      chk("R8 address kept", rd_data, 8'hAB);
      do_read();
      send_frame(8, 9'h07F, 0, 1, 0);
      chk("R8 8-bit dropped", ready, 1'b0);
      send_frame(8, 9'h080, 0, 1, 0);
      chk("R8 8-bit address", rd_data, 8'h80);
      do_read();
      addr_filt = 1'b0;
      drain();
      repeat (8) @(negedge clk);
      finish_run();
   end
endmodule